// File: doc/BRIEF.md
# Ephemeral Key Request Controller

This block owns the scrambling key and nonce used by a scrambled memory and manages their renewal. Out of reset it presents built-in default constants, so scrambling is always active. When software asks for a renewal, the block raises a request toward a key provider on the same clock. It holds that request until a one-cycle acknowledge arrives with a fresh key, a fresh nonce and a flag that says whether the provider's seeds were provisioned. The returned values are in use from the next cycle.

Memory accesses are held off while a renewal is outstanding. An escalation, either from a 4-bit multibit input or from a locally detected error pulse, wipes the key back to the defaults on the next cycle. It also stops every later memory access until reset. A sticky lock bit, once written, freezes the control register so that no further renewal can be started before reset.

Top module: `ekey_ctrl`

## Requirements
- R1: After reset, key_o and nonce_o hold the default constants, key_valid_o, seed_valid_o, prov_req_o and wiped_o are 0, and ctrl_open_o is 1.
- R2: A control write with the renew bit set, while unlocked, idle and not wiped, drives prov_req_o to 1 and key_valid_o to 0 from the next cycle. prov_req_o then stays 1 until an acknowledge is taken.
- R3: An acknowledge taken while prov_req_o is 1 makes key_o and nonce_o equal the values presented with it from the next cycle, with key_valid_o at 1 and prov_req_o at 0.
- R4: mem_gnt_o is 0 while prov_req_o is 1, and otherwise follows mem_req_i when no escalation is present or latched.
- R5: seed_valid_o shows the seed flag presented with the last acknowledge that was taken; 0 means the key came from all-zero seeds.
- R6: A renew command issued while a request is pending is ignored: after the acknowledge, prov_req_o stays 0.
- R7: Any esc_i value other than the off code 4'b1010 reloads the default key and nonce on the next cycle. It clears key_valid_o, seed_valid_o and prov_req_o, and sets wiped_o, which stays 1 until reset. mem_gnt_o is 0 in the cycle esc_i is asserted and ever after.
- R8: A one-cycle local_err_i pulse has exactly the same effect as R7, including the latched wiped_o.
- R9: A pulse on lock_we_i drives ctrl_open_o to 0 until reset, and later renew writes start no request.
- R10: An acknowledge that arrives with no pending request changes neither key_o, nonce_o nor the status bits.
- R11: When an escalation and an acknowledge fall in the same cycle, the defaults are loaded and the returned key is discarded.
- R12: Once wiped_o is 1, renew writes start no request and later acknowledges are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_renew_i | input | 1 | Renew bit of the control write data |
| lock_we_i | input | 1 | Write strobe of the sticky lock register |
| esc_i | input | ESC_W | Multibit escalation; 4'b1010 means off |
| local_err_i | input | 1 | Local integrity or counter error pulse |
| prov_req_o | output | 1 | Key request to the provider |
| prov_ack_i | input | 1 | One-cycle acknowledge from the provider |
| prov_key_i | input | KEY_W | Key returned with the acknowledge |
| prov_nonce_i | input | NONCE_W | Nonce returned with the acknowledge |
| prov_seed_ok_i | input | 1 | Seed-provisioned flag returned with the acknowledge |
| key_o | output | KEY_W | Current scrambling key |
| nonce_o | output | NONCE_W | Current scrambling nonce |
| key_valid_o | output | 1 | Key came from a completed renewal |
| seed_valid_o | output | 1 | Renewed key was derived from provisioned seeds |
| ctrl_open_o | output | 1 | 1 while the control register accepts writes |
| wiped_o | output | 1 | Escalation latched, accesses blocked |
| mem_req_i | input | 1 | Memory access request |
| mem_gnt_o | output | 1 | Memory access granted |

## Verification
The two functions that can collide in one cycle are the completion of a renewal and an escalation wipe. The bench provokes this by presenting the acknowledge with a non-default key in the same cycle as a non-off escalation code, and it expects the default key, a cleared valid bit and a latched wipe. A second collision, a renew command during a pending request, is placed between request and acknowledge and judged by prov_req_o staying low afterwards. All sixteen escalation codes are swept, each after a fresh reset and renewal. Only the off code must leave the renewed key and the grant path untouched.

// File: rtl/ekc_pkg.sv
package ekc_pkg;

   // Multibit code that means "no escalation"; every other value escalates.
   localparam logic [3:0] ESC_OFF_CODE = 4'b1010;

   typedef enum logic [1:0] {
      HS_IDLE = 2'd0,
      HS_WAIT = 2'd1,
      HS_DEAD = 2'd2
   } hs_state_e;

endpackage

// File: rtl/ekc_esc_detect.sv
module ekc_esc_detect #(
   parameter int unsigned        ESC_W   = 4,
   parameter logic [ESC_W-1:0]   ESC_OFF = 4'b1010
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [ESC_W-1:0] esc_i,
   input  logic             local_err_i,
   output logic             esc_now_o,
   output logic             wiped_o
);

   logic glob_esc;
   logic wiped_q;

   // Any deviation from the off code counts as asserted.
   assign glob_esc  = (esc_i != ESC_OFF);
   assign esc_now_o = glob_esc | local_err_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         wiped_q <= 1'b0;
      end else if (esc_now_o) begin
         wiped_q <= 1'b1;
      end
   end

   assign wiped_o = wiped_q;

endmodule

// File: rtl/ekc_handshake.sv
module ekc_handshake
   import ekc_pkg::*;
(
   input  logic clk_i,
   input  logic rst_ni,
   input  logic renew_i,
   input  logic ack_i,
   input  logic kill_i,
   output logic req_o,
   output logic start_o,
   output logic done_o
);

   hs_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      start_o = 1'b0;
      done_o  = 1'b0;
      unique case (state_q)
         HS_IDLE: begin
            if (kill_i) begin
               state_d = HS_DEAD;
            end else if (renew_i) begin
               state_d = HS_WAIT;
               start_o = 1'b1;
            end
         end
         HS_WAIT: begin
            if (kill_i) begin
               state_d = HS_DEAD;
            end else if (ack_i) begin
               state_d = HS_IDLE;
               done_o  = 1'b1;
            end
         end
         HS_DEAD: state_d = HS_DEAD;
         default: state_d = HS_DEAD;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= HS_IDLE;
      end else begin
         state_q <= state_d;
      end
   end

   assign req_o = (state_q == HS_WAIT);

endmodule

// File: rtl/ekc_key_store.sv
module ekc_key_store #(
   parameter int unsigned          KEY_W     = 128,
   parameter int unsigned          NONCE_W   = 64,
   parameter logic [KEY_W-1:0]     DEF_KEY   = '0,
   parameter logic [NONCE_W-1:0]   DEF_NONCE = '0
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               wipe_i,
   input  logic               start_i,
   input  logic               load_i,
   input  logic [KEY_W-1:0]   key_i,
   input  logic [NONCE_W-1:0] nonce_i,
   input  logic               seed_ok_i,
   output logic [KEY_W-1:0]   key_o,
   output logic [NONCE_W-1:0] nonce_o,
   output logic               key_valid_o,
   output logic               seed_valid_o
);

   logic [KEY_W-1:0]   key_q;
   logic [NONCE_W-1:0] nonce_q;
   logic               kval_q;
   logic               sval_q;

   // Wipe dominates a load in the same cycle.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         key_q   <= DEF_KEY;
         nonce_q <= DEF_NONCE;
         kval_q  <= 1'b0;
         sval_q  <= 1'b0;
      end else if (wipe_i) begin
         key_q   <= DEF_KEY;
         nonce_q <= DEF_NONCE;
         kval_q  <= 1'b0;
         sval_q  <= 1'b0;
      end else if (load_i) begin
         key_q   <= key_i;
         nonce_q <= nonce_i;
         kval_q  <= 1'b1;
         sval_q  <= seed_ok_i;
      end else if (start_i) begin
         kval_q  <= 1'b0;
      end
   end

   assign key_o        = key_q;
   assign nonce_o      = nonce_q;
   assign key_valid_o  = kval_q;
   assign seed_valid_o = sval_q;

endmodule

// File: rtl/ekc_lock.sv
module ekc_lock (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic lock_we_i,
   input  logic ctrl_we_i,
   input  logic ctrl_renew_i,
   output logic renew_o,
   output logic open_o
);

   logic locked_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         locked_q <= 1'b0;
      end else if (lock_we_i) begin
         locked_q <= 1'b1;
      end
   end

   assign open_o  = ~locked_q;
   assign renew_o = ctrl_we_i & ctrl_renew_i & ~locked_q;

endmodule

// File: rtl/ekey_ctrl.sv
module ekey_ctrl
   import ekc_pkg::*;
#(
   parameter int unsigned        KEY_W      = 128,
   parameter int unsigned        NONCE_W    = 64,
   parameter int unsigned        ESC_W      = 4,
   parameter logic [ESC_W-1:0]   ESC_OFF    = ESC_OFF_CODE,
   parameter logic [KEY_W-1:0]   DEF_KEY    = {(KEY_W+31)/32{32'h9E37_79B9}},
   parameter logic [NONCE_W-1:0] DEF_NONCE  = {(NONCE_W+31)/32{32'h7F4A_7C15}},
   parameter bit                 FAST_BLOCK = 1'b1
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               ctrl_we_i,
   input  logic               ctrl_renew_i,
   input  logic               lock_we_i,
   input  logic [ESC_W-1:0]   esc_i,
   input  logic               local_err_i,
   output logic               prov_req_o,
   input  logic               prov_ack_i,
   input  logic [KEY_W-1:0]   prov_key_i,
   input  logic [NONCE_W-1:0] prov_nonce_i,
   input  logic               prov_seed_ok_i,
   output logic [KEY_W-1:0]   key_o,
   output logic [NONCE_W-1:0] nonce_o,
   output logic               key_valid_o,
   output logic               seed_valid_o,
   output logic               ctrl_open_o,
   output logic               wiped_o,
   input  logic               mem_req_i,
   output logic               mem_gnt_o
);

   // Elaboration-time configuration checks.
   if (KEY_W < 8) begin : g_bad_key_w
      $error("KEY_W must be at least 8");
   end
   if (NONCE_W < 4) begin : g_bad_nonce_w
      $error("NONCE_W must be at least 4");
   end
   if (ESC_W < 2) begin : g_bad_esc_w
      $error("ESC_W must be at least 2 for a multibit encoding");
   end
   if ((ESC_OFF == '0) || (ESC_OFF == '1)) begin : g_bad_esc_off
      $error("ESC_OFF must mix ones and zeros");
   end

   logic renew_cmd;
   logic esc_now;
   logic hs_start;
   logic hs_done;
   logic hs_req;
   logic wiped;
   logic block_now;

   ekc_lock u_lock (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .lock_we_i    (lock_we_i),
      .ctrl_we_i    (ctrl_we_i),
      .ctrl_renew_i (ctrl_renew_i),
      .renew_o      (renew_cmd),
      .open_o       (ctrl_open_o)
   );

   ekc_esc_detect #(
      .ESC_W   (ESC_W),
      .ESC_OFF (ESC_OFF)
   ) u_esc (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .esc_i       (esc_i),
      .local_err_i (local_err_i),
      .esc_now_o   (esc_now),
      .wiped_o     (wiped)
   );

   ekc_handshake u_hs (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .renew_i (renew_cmd),
      .ack_i   (prov_ack_i),
      .kill_i  (esc_now),
      .req_o   (hs_req),
      .start_o (hs_start),
      .done_o  (hs_done)
   );

   ekc_key_store #(
      .KEY_W     (KEY_W),
      .NONCE_W   (NONCE_W),
      .DEF_KEY   (DEF_KEY),
      .DEF_NONCE (DEF_NONCE)
   ) u_store (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .wipe_i       (esc_now),
      .start_i      (hs_start),
      .load_i       (hs_done),
      .key_i        (prov_key_i),
      .nonce_i      (prov_nonce_i),
      .seed_ok_i    (prov_seed_ok_i),
      .key_o        (key_o),
      .nonce_o      (nonce_o),
      .key_valid_o  (key_valid_o),
      .seed_valid_o (seed_valid_o)
   );

   // Grant gating: the fast variant also blocks in the escalation cycle itself.
   if (FAST_BLOCK) begin : g_fast_block
      assign block_now = esc_now | wiped;
   end else begin : g_reg_block
      assign block_now = wiped;
   end

   assign mem_gnt_o  = mem_req_i & ~hs_req & ~block_now;
   assign prov_req_o = hs_req;
   assign wiped_o    = wiped;

endmodule

// File: rtl/ekc_chk.sv
module ekc_chk #(
   parameter int unsigned        KEY_W     = 128,
   parameter int unsigned        NONCE_W   = 64,
   parameter int unsigned        ESC_W     = 4,
   parameter logic [ESC_W-1:0]   ESC_OFF   = 4'b1010,
   parameter logic [KEY_W-1:0]   DEF_KEY   = '0,
   parameter logic [NONCE_W-1:0] DEF_NONCE = '0
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic [ESC_W-1:0]   esc_i,
   input logic               local_err_i,
   input logic               prov_req_o,
   input logic               prov_ack_i,
   input logic [KEY_W-1:0]   prov_key_i,
   input logic [NONCE_W-1:0] prov_nonce_i,
   input logic [KEY_W-1:0]   key_o,
   input logic [NONCE_W-1:0] nonce_o,
   input logic               key_valid_o,
   input logic               ctrl_open_o,
   input logic               wiped_o,
   input logic               mem_gnt_o
);

   logic quiet;
   assign quiet = (esc_i == ESC_OFF) && !local_err_i;

   // R2
   req_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (prov_req_o && !prov_ack_i && quiet) |=> prov_req_o);

   // R2
   valid_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(prov_req_o) |-> !key_valid_o);

   // R3
   key_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (prov_req_o && prov_ack_i && quiet) |=>
         (key_o == $past(prov_key_i) && nonce_o == $past(prov_nonce_i)
          && key_valid_o && !prov_req_o));

   // R4
   gnt_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mem_gnt_o |-> (!prov_req_o && !wiped_o));

   // R7
   esc_wipe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !quiet |=> (key_o == DEF_KEY && nonce_o == DEF_NONCE && wiped_o
                  && !key_valid_o && !prov_req_o));

   // R8
   wipe_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wiped_o |=> wiped_o);

   // R9
   lock_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ctrl_open_o |=> !ctrl_open_o);

   // R12
   dead_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wiped_o |-> !prov_req_o);

endmodule

bind ekey_ctrl ekc_chk #(
   .KEY_W     (KEY_W),
   .NONCE_W   (NONCE_W),
   .ESC_W     (ESC_W),
   .ESC_OFF   (ESC_OFF),
   .DEF_KEY   (DEF_KEY),
   .DEF_NONCE (DEF_NONCE)
) u_ekc_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .esc_i        (esc_i),
   .local_err_i  (local_err_i),
   .prov_req_o   (prov_req_o),
   .prov_ack_i   (prov_ack_i),
   .prov_key_i   (prov_key_i),
   .prov_nonce_i (prov_nonce_i),
   .key_o        (key_o),
   .nonce_o      (nonce_o),
   .key_valid_o  (key_valid_o),
   .ctrl_open_o  (ctrl_open_o),
   .wiped_o      (wiped_o),
   .mem_gnt_o    (mem_gnt_o)
);

// File: tb/tb_ekey_ctrl.sv
module tb_ekey_ctrl;

   localparam int KW = 16;
   localparam int NW = 8;
   localparam logic [KW-1:0] DK = 16'hC3A5;
   localparam logic [NW-1:0] DN = 8'h5A;
   localparam logic [3:0]    OFF = 4'b1010;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ctrl_we = 1'b0, ctrl_renew = 1'b0, lock_we = 1'b0;
   logic [3:0] esc = OFF;
   logic local_err = 1'b0;
   logic prov_req, prov_ack = 1'b0, prov_seed = 1'b0;
   logic [KW-1:0] prov_key = '0, key;
   logic [NW-1:0] prov_nonce = '0, nonce;
   logic key_valid, seed_valid, ctrl_open, wiped;
   logic mem_req = 1'b0, mem_gnt;

   int n_cmp = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   ekey_ctrl #(
      .KEY_W(KW), .NONCE_W(NW), .ESC_W(4), .ESC_OFF(OFF),
      .DEF_KEY(DK), .DEF_NONCE(DN), .FAST_BLOCK(1'b1)
   ) dut (
      .clk_i(clk), .rst_ni(rst_n), .ctrl_we_i(ctrl_we), .ctrl_renew_i(ctrl_renew),
      .lock_we_i(lock_we), .esc_i(esc), .local_err_i(local_err),
      .prov_req_o(prov_req), .prov_ack_i(prov_ack), .prov_key_i(prov_key),
      .prov_nonce_i(prov_nonce), .prov_seed_ok_i(prov_seed),
      .key_o(key), .nonce_o(nonce), .key_valid_o(key_valid),
      .seed_valid_o(seed_valid), .ctrl_open_o(ctrl_open), .wiped_o(wiped),
      .mem_req_i(mem_req), .mem_gnt_o(mem_gnt)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; ctrl_we = 0; ctrl_renew = 0; lock_we = 0; esc = OFF;
      local_err = 0; prov_ack = 0; mem_req = 0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic renew();
      ctrl_we = 1'b1; ctrl_renew = 1'b1;
      @(negedge clk);
      ctrl_we = 1'b0; ctrl_renew = 1'b0;
   endtask

   task automatic ack(input logic [KW-1:0] k, input logic [NW-1:0] n, input logic s);
      prov_ack = 1'b1; prov_key = k; prov_nonce = n; prov_seed = s;
      @(negedge clk);
      prov_ack = 1'b0; prov_key = '0; prov_nonce = '0; prov_seed = 1'b0;
   endtask

   task automatic report();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      report();
   end

   initial begin
      do_reset();
      // R1 reset state
      chk("R1 key", key, DK);
      chk("R1 nonce", nonce, DN);
      chk("R1 key_valid", key_valid, 0);
      chk("R1 seed_valid", seed_valid, 0);
      chk("R1 req", prov_req, 0);
      chk("R1 open", ctrl_open, 1);
      chk("R1 wiped", wiped, 0);
      mem_req = 1'b1; #1;
      chk("R4 idle grant", mem_gnt, 1);

      // R2 request raised and held
      renew();
      chk("R2 req raised", prov_req, 1);
      chk("R2 key_valid low", key_valid, 0);
      #1 chk("R4 grant blocked", mem_gnt, 0);
      // R6 second renew while pending
      renew();
      repeat (3) @(negedge clk);
      chk("R2 req held", prov_req, 1);
      chk("R2 key unchanged while pending", key, DK);
      ack(16'h1234, 8'h9C, 1'b1);
      chk("R3 key", key, 16'h1234);
      chk("R3 nonce", nonce, 8'h9C);
      chk("R3 key_valid", key_valid, 1);
      chk("R3 req dropped", prov_req, 0);
      chk("R5 seed_valid set", seed_valid, 1);
      @(negedge clk);
      chk("R6 no repeat req", prov_req, 0);
      #1 chk("R4 grant restored", mem_gnt, 1);

      // Sweep of renewals with varied latency and seed flags
      for (int i = 0; i < 8; i++) begin
         logic [KW-1:0] k;
         logic [NW-1:0] n;
         k = 16'h1000 + 16'(i) * 16'h0F31;
         n = 8'h11 * 8'(i) + 8'h03;
         renew();
         chk("R2 sweep valid drop", key_valid, 0);
         repeat (i) @(negedge clk);
         chk("R2 sweep req held", prov_req, 1);
         ack(k, n, i[0]);
         chk("R3 sweep key", key, k);
         chk("R3 sweep nonce", nonce, n);
         chk("R5 sweep seed", seed_valid, i[0]);
         chk("R3 sweep valid", key_valid, 1);
      end

      // R10 stray acknowledge
      ack(16'hDEAD, 8'hEE, 1'b0);
      chk("R10 key kept", key, 16'h1000 + 16'd7 * 16'h0F31);
      chk("R10 seed kept", seed_valid, 1);
      chk("R10 valid kept", key_valid, 1);

      // R9 lock
      lock_we = 1'b1; @(negedge clk); lock_we = 1'b0;
      chk("R9 open low", ctrl_open, 0);
      renew();
      chk("R9 renew ignored", prov_req, 0);
      @(negedge clk);
      chk("R9 still locked", ctrl_open, 0);

      // R7 / R12 sweep over every escalation code
      for (int c = 0; c < 16; c++) begin
         logic hot;
         hot = (4'(c) != OFF);
         do_reset();
         renew();
         ack(16'h5000 + 16'(c), 8'h40 + 8'(c), 1'b1);
         mem_req = 1'b1;
         esc = 4'(c);
         #1 chk("R7 grant in esc cycle", mem_gnt, !hot);
         @(negedge clk);
         esc = OFF;
         chk("R7 key", key, hot ? DK : 16'h5000 + 16'(c));
         chk("R7 nonce", nonce, hot ? DN : 8'h40 + 8'(c));
         chk("R7 wiped", wiped, hot);
         chk("R7 valid", key_valid, !hot);
         chk("R7 seed", seed_valid, !hot);
         #1 chk("R7 later grant", mem_gnt, !hot);
         renew();
         chk("R12 renew after wipe", prov_req, !hot);
         if (hot) begin
            ack(16'h7777, 8'h77, 1'b1);
            chk("R12 ack after wipe", key, DK);
            chk("R7 wiped sticky", wiped, 1);
         end
      end

      // R8 local error
      do_reset();
      renew();
      ack(16'hABCD, 8'h12, 1'b1);
      mem_req = 1'b1;
      local_err = 1'b1;
      #1 chk("R8 grant in err cycle", mem_gnt, 0);
      @(negedge clk);
      local_err = 1'b0;
      chk("R8 key", key, DK);
      chk("R8 nonce", nonce, DN);
      chk("R8 wiped", wiped, 1);
      repeat (2) @(negedge clk);
      chk("R8 latched", wiped, 1);
      #1 chk("R8 grant stays low", mem_gnt, 0);

      // R11 escalation and acknowledge in the same cycle
      do_reset();
      renew();
      esc = 4'b0101;
      ack(16'h4321, 8'h21, 1'b1);
      esc = OFF;
      chk("R11 key default", key, DK);
      chk("R11 nonce default", nonce, DN);
      chk("R11 valid low", key_valid, 0);
      chk("R11 req low", prov_req, 0);
      chk("R11 wiped", wiped, 1);

      report();
   end

endmodule